// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

The block sits between two 16-bit buses, A and B, and moves data in either direction. Internally the width is split into two identical 8-bit sections. Each section has its own active-low output enable, its own capture strobes (one per direction) and its own source selects (one per direction). A single direction input is shared by both sections. Each section holds two storage registers. One keeps a copy of A-bus data for sending toward B. The other keeps a copy of B-bus data for sending toward A.

Each driven output can carry either the live value from the opposite bus, with no added latency, or the contents of the matching storage register. Tri-state pins are split into separate input, output and output-enable vectors for each bus. The pad ring, or a wrapper, combines them into real bidirectional pins. Capture strobes are sampled on the system clock, and a register loads on the clock edge where its strobe is first seen high. Capture still works when a section has both buses released. This lets a controller park data in the registers while the buses are isolated.

Top module: `regbus_xcvr`

## Requirements
- R1: A synchronous active-high `rst` clears every storage register to zero. A stored-source output therefore reads zero after reset.
- R2: The A-to-B register of a section loads that section's `a_in` bits on the clock edge where its `cap_ab` bit is high and was low at the previous edge. While the strobe stays high, or stays low, the register keeps its value.
- R3: The B-to-A register of a section loads that section's `b_in` bits under the same rising-strobe rule, using its `cap_ba` bit.
- R4: A section's `b_oe` bits are all 1 exactly when its `oe_n` bit is 0 and `dir_a2b` is 1. Its `a_oe` bits are all 1 exactly when its `oe_n` bit is 0 and `dir_a2b` is 0. `a_oe` and `b_oe` are never both set for the same bit.
- R5: When a select bit is 0 (live), the section's output is the opposite bus input in the same cycle: `b_out` follows `a_in` for `sel_ab`, and `a_out` follows `b_in` for `sel_ba`.
- R6: When a select bit is 1 (stored), the section's output is its storage register, and changes on the input bus do not reach the output.
- R7: With `oe_n` high for a section, both of its enable vectors are 0, and captures in both directions still load the registers.
- R8: The enable, strobes and selects of one section act only on that section's 8 bits (bits 7:0 for section 0, bits 15:8 for section 1).
- R9: If a strobe rises and the select switches to stored in the same cycle, the output shows the old register value until the clock edge, and the newly captured value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobes are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| dir_a2b | input | 1 | Shared direction: 1 drives B, 0 drives A |
| oe_n | input | 2 | Active-low output enable, one bit per section |
| cap_ab | input | 2 | Capture strobe for the A-to-B registers, per section |
| cap_ba | input | 2 | Capture strobe for the B-to-A registers, per section |
| sel_ab | input | 2 | Source for B outputs per section: 0 live, 1 stored |
| sel_ba | input | 2 | Source for A outputs per section: 0 live, 1 stored |
| a_in | input | 16 | Value seen on the A bus |
| a_out | output | 16 | Value offered to the A bus |
| a_oe | output | 16 | Per-bit drive enable for the A bus |
| b_in | input | 16 | Value seen on the B bus |
| b_out | output | 16 | Value offered to the B bus |
| b_oe | output | 16 | Per-bit drive enable for the B bus |

## Verification
The assertions check these rules on every cycle: no section drives both buses, isolation releases both buses, a live output equals its source input, a stored output shows the data captured at the last strobe edge and holds between edges, and registers read zero after reset. The bench scenarios are needed for the rest. They show that a strobe held high does not capture a second time, that captures made during isolation appear once the outputs are enabled, that one section's controls leave the other section alone, and the order of events when a strobe rises in the same cycle the select changes.

// File: rtl/regbus_pkg.sv
package regbus_pkg;

  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_sel_e;

  // A bus is driven when the section is enabled and the direction points at it.
  function automatic logic drive_en(input logic oe_n, input logic dir_a2b,
                                    input logic toward_b);
    return !oe_n && (dir_a2b == toward_b);
  endfunction

  // Strobe seen high now after being low at the previous sample.
  function automatic logic edge_rise(input logic now_v, input logic prev_v);
    return now_v && !prev_v;
  endfunction

endpackage

// File: rtl/regbus_capture.sv
module regbus_capture
  import regbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         strobe,
  input  logic [W-1:0] din,
  output logic         fire,
  output logic [W-1:0] q
);
  logic strobe_q;

  assign fire = edge_rise(strobe, strobe_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      strobe_q <= 1'b0;
      q        <= '0;
    end else begin
      strobe_q <= strobe;
      if (fire) q <= din;
    end
  end
endmodule

// File: rtl/regbus_section.sv
module regbus_section
  import regbus_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         dir_a2b,
  input  logic         oe_n,
  input  logic         cap_ab,
  input  logic         cap_ba,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_oe,
  output logic         fire_ab,
  output logic         fire_ba
);
  logic [W-1:0] held_ab;
  logic [W-1:0] held_ba;

  regbus_capture #(.W(W)) u_cap_ab (
    .clk(clk), .rst(rst), .strobe(cap_ab), .din(a_in),
    .fire(fire_ab), .q(held_ab)
  );

  regbus_capture #(.W(W)) u_cap_ba (
    .clk(clk), .rst(rst), .strobe(cap_ba), .din(b_in),
    .fire(fire_ba), .q(held_ba)
  );

  assign b_out = (src_sel_e'(sel_ab) == SRC_STORED) ? held_ab : a_in;
  assign a_out = (src_sel_e'(sel_ba) == SRC_STORED) ? held_ba : b_in;

  assign b_oe = {W{drive_en(oe_n, dir_a2b, 1'b1)}};
  assign a_oe = {W{drive_en(oe_n, dir_a2b, 1'b0)}};
endmodule

// File: rtl/regbus_xcvr.sv
module regbus_xcvr #(
  parameter int SECTIONS = 2,
  parameter int SEC_W    = 8,
  localparam int TW      = SECTIONS * SEC_W
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                dir_a2b,
  input  logic [SECTIONS-1:0] oe_n,
  input  logic [SECTIONS-1:0] cap_ab,
  input  logic [SECTIONS-1:0] cap_ba,
  input  logic [SECTIONS-1:0] sel_ab,
  input  logic [SECTIONS-1:0] sel_ba,
  input  logic [TW-1:0]       a_in,
  output logic [TW-1:0]       a_out,
  output logic [TW-1:0]       a_oe,
  input  logic [TW-1:0]       b_in,
  output logic [TW-1:0]       b_out,
  output logic [TW-1:0]       b_oe
);
  // Capture events, brought out for the checker.
  logic [SECTIONS-1:0] fire_ab;
  logic [SECTIONS-1:0] fire_ba;

  for (genvar g = 0; g < SECTIONS; g++) begin : g_sec
    localparam int LO = g * SEC_W;
    regbus_section #(.W(SEC_W)) u_sec (
      .clk     (clk),
      .rst     (rst),
      .dir_a2b (dir_a2b),
      .oe_n    (oe_n[g]),
      .cap_ab  (cap_ab[g]),
      .cap_ba  (cap_ba[g]),
      .sel_ab  (sel_ab[g]),
      .sel_ba  (sel_ba[g]),
      .a_in    (a_in[LO +: SEC_W]),
      .b_in    (b_in[LO +: SEC_W]),
      .a_out   (a_out[LO +: SEC_W]),
      .b_out   (b_out[LO +: SEC_W]),
      .a_oe    (a_oe[LO +: SEC_W]),
      .b_oe    (b_oe[LO +: SEC_W]),
      .fire_ab (fire_ab[g]),
      .fire_ba (fire_ba[g])
    );
  end
endmodule

// File: rtl/regbus_xcvr_chk.sv
module regbus_xcvr_chk #(
  parameter int SECTIONS = 2,
  parameter int SEC_W    = 8,
  localparam int TW      = SECTIONS * SEC_W
) (
  input logic                clk,
  input logic                rst,
  input logic [SECTIONS-1:0] oe_n,
  input logic [SECTIONS-1:0] sel_ab,
  input logic [SECTIONS-1:0] sel_ba,
  input logic [TW-1:0]       a_in,
  input logic [TW-1:0]       b_in,
  input logic [TW-1:0]       a_out,
  input logic [TW-1:0]       b_out,
  input logic [TW-1:0]       a_oe,
  input logic [TW-1:0]       b_oe,
  input logic [SECTIONS-1:0] fire_ab,
  input logic [SECTIONS-1:0] fire_ba
);
  for (genvar g = 0; g < SECTIONS; g++) begin : g_chk
    localparam int LO = g * SEC_W;

    assert_no_dual_drive_R4: assert property (@(posedge clk) disable iff (rst)
      (a_oe[LO +: SEC_W] & b_oe[LO +: SEC_W]) == '0);

    assert_isolate_R7: assert property (@(posedge clk) disable iff (rst)
      oe_n[g] |-> (a_oe[LO +: SEC_W] == '0) && (b_oe[LO +: SEC_W] == '0));

    assert_live_ab_R5: assert property (@(posedge clk) disable iff (rst)
      !sel_ab[g] |-> b_out[LO +: SEC_W] == a_in[LO +: SEC_W]);

    assert_live_ba_R5: assert property (@(posedge clk) disable iff (rst)
      !sel_ba[g] |-> a_out[LO +: SEC_W] == b_in[LO +: SEC_W]);

    assert_capture_ab_R2: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(fire_ab[g]) && sel_ab[g])
        |-> b_out[LO +: SEC_W] == $past(a_in[LO +: SEC_W]));

    assert_capture_ba_R3: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && $past(fire_ba[g]) && sel_ba[g])
        |-> a_out[LO +: SEC_W] == $past(b_in[LO +: SEC_W]));

    assert_hold_ab_R6: assert property (@(posedge clk) disable iff (rst)
      (!$past(rst) && !$past(fire_ab[g]) && sel_ab[g] && $past(sel_ab[g]))
        |-> $stable(b_out[LO +: SEC_W]));

    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
      ($past(rst) && sel_ab[g]) |-> b_out[LO +: SEC_W] == '0);
  end
endmodule

bind regbus_xcvr regbus_xcvr_chk #(.SECTIONS(SECTIONS), .SEC_W(SEC_W)) u_chk (
  .clk(clk), .rst(rst), .oe_n(oe_n), .sel_ab(sel_ab), .sel_ba(sel_ba),
  .a_in(a_in), .b_in(b_in), .a_out(a_out), .b_out(b_out),
  .a_oe(a_oe), .b_oe(b_oe), .fire_ab(fire_ab), .fire_ba(fire_ba)
);

// File: tb/regbus_xcvr_bench.sv
`timescale 1ns/1ps
module regbus_xcvr_bench;
  localparam int S  = 2;
  localparam int W  = 8;
  localparam int TW = S * W;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst, dir_a2b;
  logic [S-1:0]  oe_n, cap_ab, cap_ba, sel_ab, sel_ba;
  logic [TW-1:0] a_in, b_in, a_out, b_out, a_oe, b_oe;

  regbus_xcvr u_regbus_xcvr (
    .clk(clk), .rst(rst), .dir_a2b(dir_a2b), .oe_n(oe_n),
    .cap_ab(cap_ab), .cap_ba(cap_ba), .sel_ab(sel_ab), .sel_ba(sel_ba),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  int errors = 0;
  int checks = 0;

  // Bench model of the storage registers and last strobe samples.
  logic [TW-1:0] m_ab, m_ba;
  logic [S-1:0]  p_ab, p_ba;

  task automatic chk(input string req, input logic [TW-1:0] act,
                     input logic [TW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [TW-1:0] exp_src(input logic [S-1:0] sel,
      input logic [TW-1:0] live, input logic [TW-1:0] stored);
    logic [TW-1:0] r;
    for (int s = 0; s < S; s++)
      r[s*W +: W] = sel[s] ? stored[s*W +: W] : live[s*W +: W];
    return r;
  endfunction

  function automatic logic [TW-1:0] exp_en(input logic [S-1:0] en_n,
      input logic dir, input logic toward_b);
    logic [TW-1:0] r;
    for (int s = 0; s < S; s++)
      r[s*W +: W] = (!en_n[s] && (dir == toward_b)) ? '1 : '0;
    return r;
  endfunction

  task automatic step();
    @(posedge clk);
    for (int s = 0; s < S; s++) begin
      if (rst) begin
        m_ab[s*W +: W] = '0; m_ba[s*W +: W] = '0;
        p_ab[s] = 1'b0;      p_ba[s] = 1'b0;
      end else begin
        if (cap_ab[s] && !p_ab[s]) m_ab[s*W +: W] = a_in[s*W +: W];
        if (cap_ba[s] && !p_ba[s]) m_ba[s*W +: W] = b_in[s*W +: W];
        p_ab[s] = cap_ab[s];
        p_ba[s] = cap_ba[s];
      end
    end
    @(negedge clk);
  endtask

  task automatic check_all();
    chk("R4 b_oe", b_oe, exp_en(oe_n, dir_a2b, 1'b1));
    chk("R4 a_oe", a_oe, exp_en(oe_n, dir_a2b, 1'b0));
    chk("R5/R6 b_out", b_out, exp_src(sel_ab, a_in, m_ab));
    chk("R5/R6 a_out", a_out, exp_src(sel_ba, b_in, m_ba));
  endtask

  initial begin
    #1ms;
    errors++;
    checks++;
    $display("FAIL watchdog all-requirements actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    seed_v = $urandom(32'h5EED_0042);
    m_ab = '0; m_ba = '0; p_ab = '0; p_ba = '0;
    rst = 1'b1; dir_a2b = 1'b1; oe_n = '1;
    cap_ab = '0; cap_ba = '0; sel_ab = '0; sel_ba = '0;
    a_in = '0; b_in = '0;
    @(negedge clk);
    step(); step();
    rst = 1'b0;

    // R1: stored outputs read zero after reset
    sel_ab = '1; sel_ba = '1; oe_n = '0; dir_a2b = 1'b1;
    a_in = 16'hFFFF; b_in = 16'hFFFF;
    #1 chk("R1 b_out after reset", b_out, 16'h0000);
    dir_a2b = 1'b0;
    #1 chk("R1 a_out after reset", a_out, 16'h0000);
    chk("R4 a_oe toward A", a_oe, 16'hFFFF);
    chk("R4 b_oe released", b_oe, 16'h0000);

    // R7: isolation, captures in both directions
    oe_n = '1; a_in = 16'hA55A; b_in = 16'h3C3C; cap_ab = '1; cap_ba = '1;
    #1 chk("R7 a_oe isolated", a_oe, 16'h0000);
    chk("R7 b_oe isolated", b_oe, 16'h0000);
    step();
    oe_n = '0; dir_a2b = 1'b1;
    #1 chk("R7 b_out captured while isolated", b_out, 16'hA55A);
    chk("R4 b_oe toward B", b_oe, 16'hFFFF);
    dir_a2b = 1'b0;
    #1 chk("R3 a_out captured B data", a_out, 16'h3C3C);

    // R2: strobe held high does not reload
    a_in = 16'h1234;
    step();
    dir_a2b = 1'b1;
    #1 chk("R2 held strobe keeps value", b_out, 16'hA55A);

    // R8: only section 0 strobes
    cap_ab = '0; cap_ba = '0;
    step();
    a_in = 16'h7788; cap_ab = 2'b01;
    step();
    #1 chk("R8 section 0 only captures", b_out, 16'hA588);
    oe_n = 2'b10;
    #1 chk("R8 per-section enable", b_oe, 16'h00FF);

    // R9: strobe rise and select change in the same cycle
    cap_ab = '0; oe_n = '0;
    step();
    sel_ab = '0; a_in = 16'h0F0F;
    #1 chk("R5 live pass-through", b_out, 16'h0F0F);
    sel_ab = '1; cap_ab = '1;
    #1 chk("R9 old value before edge", b_out, 16'hA588);
    step();
    #1 chk("R9 new value after edge", b_out, 16'h0F0F);
    a_in = 16'hFFFF;
    #1 chk("R6 stored ignores input", b_out, 16'h0F0F);
    cap_ab = '0;
    step();

    // Random phase against the bench model
    for (int i = 0; i < 600; i++) begin
      dir_a2b = 1'($urandom);
      oe_n    = S'($urandom);
      cap_ab  = S'($urandom);
      cap_ba  = S'($urandom);
      sel_ab  = S'($urandom);
      sel_ba  = S'($urandom);
      a_in    = TW'($urandom);
      b_in    = TW'($urandom);
      #1 check_all();
      step();
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule